// File: doc/BRIEF.md
# PIE Command Framer

This block turns a reader command, delivered one bit at a time, into a pulse-interval-encoded amplitude stream for a transmit DAC. The command bits are collected into an internal buffer. When the final bit arrives, the block latches its per-command settings: CRC-5 or CRC-16, one of three symbol lengths, a full preamble or a short frame-sync, the delimiter and TRcal lengths, and the low-level code. It then plays out a header, the command bits and the chosen CRC as PIE symbols.

Every output sample lasts a quarter of the selected symbol length. This interval is called a tick. A data-0 is 4 ticks and a data-1 is 8 ticks. Every symbol ends with 2 low ticks. During a packet the output holds either a full-scale high code or the programmed modulation-depth code. Between packets it rests at full scale, which is the continuous carrier. A one-cycle done pulse closes each packet. The next command can start loading in that same cycle.

Top module: `pie_cmd_framer`

## Requirements
- R1: A bit is taken on each cycle where `bit_valid_i` and `bit_ready_o` are both high. `bit_last_i` marks the final bit and starts the packet. All configuration inputs are sampled in that cycle. The first bit taken is sent first.
- R2: While `busy_o` is high, `bit_ready_o` is low. Bits offered during a packet do not enter the next command.
- R3: Each packet sample lasts `TICK_DIV` x 1, 2 or 4 clock cycles for `tari_sel_i` = 0, 1 or 2. `sample_stb_o` is high for one cycle at the start of each sample.
- R4: Data-0 is 2 high ticks then 2 low ticks. Data-1 is 6 high ticks then 2 low ticks.
- R5: With `preamble_sel_i`=1, the header is built as follows, in this order:
  - `delim_ticks_i` low ticks;
  - a data-0;
  - RTcal, which is 10 high ticks then 2 low ticks;
  - TRcal, which is (`trcal_ticks_i`-2) high ticks then 2 low ticks.
- R6: With `preamble_sel_i`=0, the header is the same without TRcal.
- R7: With `crc16_sel_i`=0, a CRC-5 follows the payload, MSB first. It uses polynomial x^5+x^3+1, preset 01001, and covers the command bits.
- R8: With `crc16_sel_i`=1, a CRC-16 follows the payload. It uses polynomial x^16+x^12+x^5+1 and preset FFFF. The ones' complement of the register is sent MSB first.
- R9: A high tick outputs code 255 and a low tick outputs `low_code_i`. Outside a packet `sample_o` is 255.
- R10: `done_o` pulses for one cycle, one tick period after the last sample starts. `busy_o` falls in that cycle and `sample_o` returns to 255.
- R11: A bit offered while a packet ends is taken in the `done_o` cycle as the first bit of the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_valid_i | input | 1 | Command bit offered |
| bit_i | input | 1 | Command bit value |
| bit_last_i | input | 1 | Offered bit is the final command bit |
| bit_ready_o | output | 1 | Bit can be accepted |
| crc16_sel_i | input | 1 | 1: CRC-16, 0: CRC-5 |
| tari_sel_i | input | 2 | Symbol length select (0, 1, 2) |
| preamble_sel_i | input | 1 | 1: preamble, 0: frame-sync |
| delim_ticks_i | input | LW | Delimiter length in ticks (at least 1) |
| trcal_ticks_i | input | LW | TRcal length in ticks (14 to 36) |
| low_code_i | input | 8 | Amplitude code for low ticks |
| sample_o | output | 8 | DAC amplitude code |
| sample_stb_o | output | 1 | New packet sample this cycle |
| busy_o | output | 1 | Packet in progress |
| done_o | output | 1 | Packet finished (one cycle) |

## Verification
Two events can share a cycle: the end of one packet and the acceptance of the first bit of the next command. The bench provokes this by holding the next command's first bit valid for the whole of a packet. It then checks that the bit is taken exactly in the cycle where `done_o` is high. It also checks that the second packet plays out sample for sample as computed, with its own CRC. A separate packet floods the input with final bits while busy. The command that follows must show none of them.

// File: rtl/pie_pkg.sv
package pie_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_DELIM, PH_DATA0, PH_RTCAL, PH_TRCAL, PH_PAY, PH_CRC, PH_FIN
  } phase_e;

  localparam logic [7:0] HIGH_CODE   = 8'hFF;
  localparam int         D0_TICKS    = 4;
  localparam int         D1_TICKS    = 8;
  localparam int         RTCAL_TICKS = D0_TICKS + D1_TICKS;
  localparam logic [4:0]  CRC5_INIT  = 5'b01001;
  localparam logic [15:0] CRC16_INIT = 16'hFFFF;
endpackage

// File: rtl/pie_tick.sv
module pie_tick #(
  parameter int TICK_DIV = 2,
  localparam int DIV_W   = $clog2(4 * TICK_DIV + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] tari_i,
  output logic       tick_o
);
  logic [DIV_W-1:0] cnt_q, div;

  always_comb begin
    case (tari_i)
      2'd0:    div = DIV_W'(TICK_DIV);
      2'd1:    div = DIV_W'(2 * TICK_DIV);
      default: div = DIV_W'(4 * TICK_DIV);
    endcase
  end

  assign tick_o = run_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= div - 1'b1;
    else              cnt_q <= cnt_q - 1'b1;
  end

  // TICK_DIV >= 2 keeps ticks apart
  a_r3_tick_spaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/pie_seg.sv
module pie_seg #(
  parameter int LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [LW-1:0] len_i,
  input  logic          low_all_i,
  output logic          low_o,
  output logic          end_o
);
  logic [LW-1:0] cnt_q;
  logic [LW:0]   pos;

  assign pos   = {1'b0, cnt_q};
  assign low_o = low_all_i || (pos + (LW+1)'(2) >= {1'b0, len_i});
  assign end_o = tick_i && (pos + (LW+1)'(1) == {1'b0, len_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (end_o)   cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  a_r4_pos_in_symbol: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_i != '0) |-> (cnt_q < len_i));
endmodule

// File: rtl/pie_crc.sv
module pie_crc (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic        bit_i,
  output logic [4:0]  crc5_o,
  output logic [15:0] crc16_o
);
  import pie_pkg::*;
  logic fb5, fb16;

  assign fb5  = bit_i ^ crc5_o[4];
  assign fb16 = bit_i ^ crc16_o[15];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || clr_i) begin
      crc5_o  <= CRC5_INIT;
      crc16_o <= CRC16_INIT;
    end else if (en_i) begin
      crc5_o  <= {crc5_o[3], crc5_o[2] ^ fb5, crc5_o[1:0], fb5};
      crc16_o <= {crc16_o[14:12], crc16_o[11] ^ fb16, crc16_o[10:5],
                  crc16_o[4] ^ fb16, crc16_o[3:0], fb16};
    end
  end

  a_r7_crc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> ($stable(crc5_o) && $stable(crc16_o)));
endmodule

// File: rtl/pie_cmd_framer.sv
module pie_cmd_framer #(
  parameter int MAX_BITS = 32,
  parameter int TICK_DIV = 2,
  parameter int LW       = 8,
  localparam int IW = (MAX_BITS > 2) ? $clog2(MAX_BITS) : 1,
  localparam int CW = $clog2(MAX_BITS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_valid_i,
  input  logic          bit_i,
  input  logic          bit_last_i,
  output logic          bit_ready_o,
  input  logic          crc16_sel_i,
  input  logic [1:0]    tari_sel_i,
  input  logic          preamble_sel_i,
  input  logic [LW-1:0] delim_ticks_i,
  input  logic [LW-1:0] trcal_ticks_i,
  input  logic [7:0]    low_code_i,
  output logic [7:0]    sample_o,
  output logic          sample_stb_o,
  output logic          busy_o,
  output logic          done_o
);
  import pie_pkg::*;

  phase_e              phase_q;
  logic [MAX_BITS-1:0] buf_q;
  logic [CW-1:0]       cnt_q;
  logic [IW-1:0]       idx_q;
  logic [15:0]         crc_sh_q;
  logic [4:0]          crc_left_q;
  logic                c16_q, pre_q;
  logic [1:0]          tari_q;
  logic [LW-1:0]       delim_q, trcal_q;
  logic [7:0]          low_q;

  logic accept, start, tick, seg_tick, fin_tick, seg_low, seg_end, low_all;
  logic [LW-1:0] seg_len;
  logic [4:0]    crc5;
  logic [15:0]   crc16;

  assign bit_ready_o = !busy_o && (cnt_q < CW'(MAX_BITS));
  assign accept      = bit_valid_i && bit_ready_o;
  assign start       = accept && bit_last_i;
  assign fin_tick    = tick && (phase_q == PH_FIN);
  assign seg_tick    = tick && (phase_q != PH_FIN);

  pie_tick #(.TICK_DIV(TICK_DIV)) i_tick (
    .clk_i, .rst_ni, .run_i(busy_o), .tari_i(tari_q), .tick_o(tick));

  pie_crc i_crc (
    .clk_i, .rst_ni, .clr_i(fin_tick), .en_i(accept), .bit_i,
    .crc5_o(crc5), .crc16_o(crc16));

  pie_seg #(.LW(LW)) i_seg (
    .clk_i, .rst_ni, .clr_i(start), .tick_i(seg_tick), .len_i(seg_len),
    .low_all_i(low_all), .low_o(seg_low), .end_o(seg_end));

  always_comb begin
    low_all = 1'b0;
    seg_len = LW'(D0_TICKS);
    case (phase_q)
      PH_DELIM: begin seg_len = delim_q; low_all = 1'b1; end
      PH_RTCAL: seg_len = LW'(RTCAL_TICKS);
      PH_TRCAL: seg_len = trcal_q;
      PH_PAY:   seg_len = buf_q[idx_q]  ? LW'(D1_TICKS) : LW'(D0_TICKS);
      PH_CRC:   seg_len = crc_sh_q[15]  ? LW'(D1_TICKS) : LW'(D0_TICKS);
      default:  seg_len = LW'(D0_TICKS);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;  buf_q <= '0;  cnt_q <= '0;  idx_q <= '0;
      crc_sh_q <= '0;  crc_left_q <= '0;
      c16_q <= 1'b0;  pre_q <= 1'b0;  tari_q <= '0;
      delim_q <= '0;  trcal_q <= '0;  low_q <= '0;
      sample_o <= HIGH_CODE;  sample_stb_o <= 1'b0;
      busy_o <= 1'b0;  done_o <= 1'b0;
    end else begin
      sample_stb_o <= 1'b0;
      done_o       <= 1'b0;
      if (accept) begin
        buf_q <= {buf_q[MAX_BITS-2:0], bit_i};
        cnt_q <= cnt_q + 1'b1;
      end
      if (start) begin
        c16_q <= crc16_sel_i;  pre_q <= preamble_sel_i;  tari_q <= tari_sel_i;
        delim_q <= delim_ticks_i;  trcal_q <= trcal_ticks_i;  low_q <= low_code_i;
        idx_q   <= cnt_q[IW-1:0];
        phase_q <= PH_DELIM;
        busy_o  <= 1'b1;
      end
      if (fin_tick) begin
        sample_o <= HIGH_CODE;
        done_o   <= 1'b1;
        busy_o   <= 1'b0;
        phase_q  <= PH_IDLE;
        cnt_q    <= '0;
      end else if (seg_tick) begin
        sample_o     <= seg_low ? low_q : HIGH_CODE;
        sample_stb_o <= 1'b1;
      end
      if (seg_end) begin
        case (phase_q)
          PH_DELIM: phase_q <= PH_DATA0;
          PH_DATA0: phase_q <= PH_RTCAL;
          PH_RTCAL: phase_q <= pre_q ? PH_TRCAL : PH_PAY;
          PH_TRCAL: phase_q <= PH_PAY;
          PH_PAY: begin
            if (idx_q == '0) begin
              phase_q    <= PH_CRC;
              crc_sh_q   <= c16_q ? ~crc16 : {crc5, 11'b0};
              crc_left_q <= c16_q ? 5'd15 : 5'd4;
            end else begin
              idx_q <= idx_q - 1'b1;
            end
          end
          PH_CRC: begin
            if (crc_left_q == '0) phase_q <= PH_FIN;
            else begin
              crc_sh_q   <= {crc_sh_q[14:0], 1'b0};
              crc_left_q <= crc_left_q - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_busy_ends_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  a_r9_idle_cw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (sample_o == HIGH_CODE));
  a_r9_two_levels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_stb_o |-> (sample_o == HIGH_CODE || sample_o == low_q));
  a_r2_buffer_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(buf_q));
endmodule

// File: tb/test_pie_cmd_framer.sv
module test_pie_cmd_framer;
  localparam int TD = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bv = 1'b0, bd = 1'b0, bl = 1'b0, c16 = 1'b0, pre = 1'b0;
  logic [1:0] tari = '0;
  logic [7:0] delim = 8'd1, trcal = 8'd14, low = 8'd0;
  logic bit_ready_o, sample_stb_o, busy_o, done_o;
  logic [7:0] sample_o;

  always #2.5 clk = ~clk;

  pie_cmd_framer #(.MAX_BITS(32), .TICK_DIV(TD), .LW(8)) i_pie_cmd_framer (
    .clk_i(clk), .rst_ni(rst_n), .bit_valid_i(bv), .bit_i(bd), .bit_last_i(bl),
    .bit_ready_o, .crc16_sel_i(c16), .tari_sel_i(tari), .preamble_sel_i(pre),
    .delim_ticks_i(delim), .trcal_ticks_i(trcal), .low_code_i(low),
    .sample_o, .sample_stb_o, .busy_o, .done_o);

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected packet
  bit   exp_hi [0:1023];
  int   exp_n = 0, exp_div = TD;
  logic [7:0] exp_low = 0;
  string exp_tag = "";

  task automatic exp_seg(input int len, input bit all_low);
    for (int k = 0; k < len; k++) begin
      exp_hi[exp_n] = !(all_low || k >= len - 2);
      exp_n++;
    end
  endtask

  task automatic build_exp(input logic [31:0] v, input int n, input bit s16,
                           input int ts, input bit sp, input int dl, input int tc,
                           input logic [7:0] lc, input string tag);
    logic [15:0] c; logic [4:0] c5; bit fb;
    exp_n = 0; exp_low = lc; exp_tag = tag;
    exp_div = TD * (ts == 0 ? 1 : ts == 1 ? 2 : 4);
    exp_seg(dl, 1); exp_seg(4, 0); exp_seg(12, 0);
    if (sp) exp_seg(tc, 0);
    c = 16'hFFFF; c5 = 5'b01001;
    for (int i = n - 1; i >= 0; i--) begin
      exp_seg(v[i] ? 8 : 4, 0);
      fb = v[i] ^ c[15]; c = {c[14:0], 1'b0}; if (fb) c = c ^ 16'h1021;
      fb = v[i] ^ c5[4]; c5 = {c5[3:0], 1'b0}; if (fb) c5 = c5 ^ 5'b01001;
    end
    if (s16) begin
      c = ~c;
      for (int i = 15; i >= 0; i--) exp_seg(c[i] ? 8 : 4, 0);
    end else
      for (int i = 4; i >= 0; i--) exp_seg(c5[i] ? 8 : 4, 0);
  endtask

  // monitor
  logic [7:0] smp [0:1023];
  int n_smp = 0, gap = 0, gap_err = 0, done_cnt = 0;
  always @(negedge clk) begin
    gap++;
    if (sample_stb_o) begin
      if (n_smp > 0 && gap != exp_div) gap_err++;
      if (n_smp < 1024) smp[n_smp] = sample_o;
      n_smp++;
      gap = 0;
    end
    if (done_o) begin
      int bad = 0;
      chk(n_smp == exp_n, {exp_tag, " sample count"}, n_smp, exp_n);
      for (int i = 0; i < exp_n && i < n_smp; i++)
        if (smp[i] != (exp_hi[i] ? 8'hFF : exp_low)) bad++;
      chk(bad == 0, {exp_tag, " R4 symbol levels mismatched"}, bad, 0);
      chk(gap_err == 0, "R3 tick spacing errors", gap_err, 0);
      chk(gap == exp_div, "R10 done one tick after last sample", gap, exp_div);
      chk(sample_o == 8'hFF && !busy_o, "R9 back to CW at done", sample_o, 255);
      n_smp = 0; gap_err = 0; done_cnt++;
    end
  end

  bit acc_done;
  task automatic drive_bit(input bit b, input bit last);
    bv = 1'b1; bd = b; bl = last;
    while (!bit_ready_o) @(negedge clk);
    acc_done = done_o;
    @(negedge clk);
  endtask

  task automatic cfg(input bit s16, input int ts, input bit sp, input int dl,
                     input int tc, input logic [7:0] lc);
    c16 = s16; tari = 2'(ts); pre = sp; delim = 8'(dl); trcal = 8'(tc); low = lc;
  endtask

  task automatic run_pkt(input logic [31:0] v, input int n, input bit s16,
                         input int ts, input bit sp, input int dl, input int tc,
                         input logic [7:0] lc, input string tag);
    int d0;
    build_exp(v, n, s16, ts, sp, dl, tc, lc, tag);
    cfg(s16, ts, sp, dl, tc, lc);
    d0 = done_cnt;
    for (int i = n - 1; i >= 0; i--) drive_bit(v[i], i == 0);
    bv = 1'b0; bl = 1'b0;
    wait (done_cnt == d0 + 1);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(sample_o == 8'hFF, "R9 reset level", sample_o, 255);
    chk(!busy_o, "R10 reset busy", busy_o, 0);
    chk(!done_o, "R10 reset done", done_o, 0);
    chk(bit_ready_o, "R1 reset ready", bit_ready_o, 1);
  endtask

  task automatic t_preamble_crc16;
    run_pkt(32'hA5C3, 16, 1, 0, 1, 6, 20, 8'd25, "R1 R5 R8");
  endtask

  task automatic t_framesync_crc5;
    run_pkt(32'hD2, 8, 0, 1, 0, 3, 30, 8'd0, "R6 R7");
  endtask

  task automatic t_slow_single_bit;
    run_pkt(32'h1, 1, 0, 2, 1, 10, 14, 8'd64, "R3 R7");
  endtask

  task automatic t_busy_ignore;
    int d0, ready_seen;
    build_exp(32'h6, 4, 1, 0, 0, 2, 14, 8'd25, "R2 first");
    cfg(1, 0, 0, 2, 14, 8'd25);
    d0 = done_cnt;
    for (int i = 3; i >= 0; i--) drive_bit(i == 1 || i == 2, i == 0);
    ready_seen = 0;
    bv = 1'b1; bd = 1'b1; bl = 1'b1;
    repeat (40) begin
      if (bit_ready_o) ready_seen++;
      @(negedge clk);
    end
    chk(ready_seen == 0 && busy_o, "R2 ready low while busy", ready_seen, 0);
    bv = 1'b0; bl = 1'b0;
    wait (done_cnt == d0 + 1);
    @(negedge clk);
    run_pkt(32'h5, 3, 1, 0, 1, 4, 25, 8'd25, "R2 next command clean");
  endtask

  task automatic t_back_to_back;
    int d0;
    build_exp(32'h13, 5, 0, 0, 1, 3, 18, 8'd10, "R11 first");
    cfg(0, 0, 1, 3, 18, 8'd10);
    d0 = done_cnt;
    for (int i = 4; i >= 0; i--) drive_bit((32'h13 >> i) & 1, i == 0);
    drive_bit(1'b0, 1'b0);  // first bit of 6'b011101, waits through the packet
    chk(acc_done, "R11 bit taken in done cycle", acc_done, 1);
    chk(done_cnt == d0 + 1, "R11 first packet closed", done_cnt, d0 + 1);
    build_exp(32'h1D, 6, 1, 0, 1, 5, 22, 8'd40, "R11 second");
    cfg(1, 0, 1, 5, 22, 8'd40);
    for (int i = 4; i >= 0; i--) drive_bit((32'h1D >> i) & 1, i == 0);
    bv = 1'b0; bl = 1'b0;
    wait (done_cnt == d0 + 2);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_preamble_crc16();
    t_framesync_crc5();
    t_slow_single_bit();
    t_busy_ignore();
    t_back_to_back();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule